// File: doc/BRIEF.md
# Horizontal Drive Clock-Source Switcher

This block produces the horizontal drive pulse train `hout` from one of two unrelated clocks. In normal operation the PLL-derived line clock times the output, with a programmable line length and high time. The output moves to a free-running standby clock when software sets the drive-off control bit or when the supply monitor raises a power-down request. Either request has the same effect. In standby the high and low times are each a fixed half period, so the duty cycle is exactly 50%.

Each clock domain owns a toggle flop, and `hout` is the XOR of the two flops. Only the domain that holds the single ownership token may toggle its flop. The owner keeps the token until the end of its current phase. It then releases the token without making an edge, and passes it through a two-flop synchronizer to the other domain. The new owner makes the delayed edge on taking the token. As a result, the phase in flight at a handover can only grow, and never by more than a few cycles of the incoming clock. The status output `src_sby` shows when the standby domain drives the pin, so the rest of the device can wait for it before it powers down.

Top module: `hdrive_src_switch`

## Requirements
- R1: While `rst` is high, `hout` and `src_sby` are both low. After reset the PLL domain drives `hout`, starting with a low phase.
- R2: When the PLL domain drives `hout`, the output is high for `high_len` PLL cycles and low for `line_len - high_len` PLL cycles.
- R3: When the standby domain drives `hout`, the output is high for SBY_HALF standby cycles and low for SBY_HALF standby cycles.
- R4: Setting `hdrv_off` to 1 moves the drive to the standby domain.
- R5: Setting `pwr_down` to 1 has the same effect as `hdrv_off`. The standby domain keeps the drive while either input is 1.
- R6: On entry to standby, the phase in flight is never shorter than its nominal PLL length. It is never longer than that length plus 4 standby clock periods.
- R7: When both requests are 0, the drive returns to PLL timing. The phase at that handover is never shorter than SBY_HALF standby periods. It is never longer than that plus 4 PLL clock periods.
- R8: `src_sby` is 1 exactly while the standby domain holds the drive. It rises together with the first standby-timed edge of `hout`.
- R9: `hout` never shows a phase shorter than the shortest nominal phase of the active settings.
- R10: At no time do both domains hold the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL-derived line clock |
| clk_sby | input | 1 | Free-running standby clock |
| rst | input | 1 | Synchronous active-high reset, held across several cycles of both clocks |
| line_len | input | CW | Line period in PLL cycles |
| high_len | input | CW | High time in PLL cycles |
| hdrv_off | input | 1 | Software drive-off bit; 1 requests standby |
| pwr_down | input | 1 | Supply-monitor power-down request; 1 requests standby |
| hout | output | 1 | Horizontal drive output |
| src_sby | output | 1 | 1 when the standby clock drives `hout` |

## Verification
The assertions assume the following about the inputs:
- `high_len` is at least 1 and below `line_len`, and neither changes while the PLL domain drives the output.
- Reset is held long enough for every synchronizer stage in both domains to clear.
- The standby half period spans at least one standby cycle, so a peer's last toggle settles through its synchronizer before the token does.

The stimulus meets these assumptions. It holds reset for many cycles of the slower clock. It changes the line settings only while standby is active. It runs the two clocks at unrelated periods, so handovers land at varying points in the phase.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    SRC_PLL = 1'b0,
    SRC_SBY = 1'b1
  } hd_src_e;
endpackage

// File: rtl/hd_sync.sv
module hd_sync #(
  parameter int W      = 1,
  parameter int STAGES = hd_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[gi] <= '0;
      else     stg[gi] <= stg[gi-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hd_domain.sv
module hd_domain
  import hd_pkg::*;
#(
  parameter int      CW       = 12,
  parameter hd_src_e DOMAIN   = SRC_PLL,
  parameter bit      INIT_OWN = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_async,
  input  logic          tok_in,
  input  logic          peer_t,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] lo_len,
  output logic          t_q,
  output logic          tok_q,
  output logic          own_q
);
  localparam logic WANT_LVL = (DOMAIN == SRC_SBY);

  logic [2:0]    syn_q;
  logic          req_s, tok_s, peer_s;
  logic          want_s, lvl, take, phase_end, seen_q;
  logic [CW-1:0] cnt_q, len;
  logic [CW:0]   cnt_nx;

  hd_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({req_async, tok_in, peer_t}),
    .q   (syn_q)
  );

  assign {req_s, tok_s, peer_s} = syn_q;
  assign want_s    = (req_s == WANT_LVL);
  assign lvl       = t_q ^ peer_s;
  assign len       = lvl ? hi_len : lo_len;
  assign cnt_nx    = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign phase_end = own_q && (cnt_nx >= {1'b0, len});
  assign take      = !own_q && (tok_s != seen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= INIT_OWN;
      t_q    <= 1'b0;
      tok_q  <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take) begin
      own_q  <= 1'b1;
      seen_q <= tok_s;
      t_q    <= ~t_q;
      cnt_q  <= '0;
    end else if (phase_end) begin
      cnt_q <= '0;
      if (want_s) begin
        t_q <= ~t_q;
      end else begin
        own_q <= 1'b0;
        tok_q <= ~tok_q;
      end
    end else if (own_q) begin
      cnt_q <= cnt_nx[CW-1:0];
    end
  end

  // R9: the local toggle flop moves only under ownership
  p_toggle_owner_r9: assert property (@(posedge clk) disable iff (rst)
    (t_q != $past(t_q)) |-> own_q);

  // R6/R7: a toggle made by a continuing owner closes a full-length phase
  p_full_phase_r6: assert property (@(posedge clk) disable iff (rst)
    (own_q && $past(own_q) && (t_q != $past(t_q))) |-> ($past(cnt_nx) >= {1'b0, $past(len)}));

  // R7: ownership is released only when the other source is requested
  p_release_unwanted_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(own_q) |-> !$past(want_s));

  // R10: the outgoing token moves only with a release
  p_token_release_r10: assert property (@(posedge clk) disable iff (rst)
    (tok_q != $past(tok_q)) |-> $fell(own_q));
endmodule

// File: rtl/hdrive_src_switch.sv
module hdrive_src_switch
  import hd_pkg::*;
#(
  parameter int CW       = 12,
  parameter int SBY_HALF = 8
) (
  input  logic          clk_pll,
  input  logic          clk_sby,
  input  logic          rst,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] high_len,
  input  logic          hdrv_off,
  input  logic          pwr_down,
  output logic          hout,
  output logic          src_sby
);
  localparam logic [CW-1:0] SBY_LEN = SBY_HALF[CW-1:0];

  logic          sby_req;
  logic [CW-1:0] low_len;
  logic          t_p, t_s, tok_p, tok_s, own_p, own_s;

  assign sby_req = hdrv_off | pwr_down;
  assign low_len = line_len - high_len;

  hd_domain #(.CW(CW), .DOMAIN(SRC_PLL), .INIT_OWN(1'b1)) u_pll (
    .clk       (clk_pll),
    .rst       (rst),
    .req_async (sby_req),
    .tok_in    (tok_s),
    .peer_t    (t_s),
    .hi_len    (high_len),
    .lo_len    (low_len),
    .t_q       (t_p),
    .tok_q     (tok_p),
    .own_q     (own_p)
  );

  hd_domain #(.CW(CW), .DOMAIN(SRC_SBY), .INIT_OWN(1'b0)) u_sby (
    .clk       (clk_sby),
    .rst       (rst),
    .req_async (sby_req),
    .tok_in    (tok_p),
    .peer_t    (t_p),
    .hi_len    (SBY_LEN),
    .lo_len    (SBY_LEN),
    .t_q       (t_s),
    .tok_q     (tok_s),
    .own_q     (own_s)
  );

  assign hout    = t_p ^ t_s;
  assign src_sby = own_s;

  // R10: never two drivers
  p_one_owner_r10: assert property (@(posedge clk_pll) disable iff (rst)
    !(own_p && own_s));
endmodule

// File: tb/sim_hdrive_src_switch.sv
`timescale 1ns/1ps
module sim_hdrive_src_switch;
  localparam int      CW    = 12;
  localparam int      HALF  = 8;
  localparam realtime TPLL  = 20.0;
  localparam realtime TSBY  = 73.0;
  localparam realtime EPS   = 0.5;

  logic          clk_pll = 1'b0, clk_sby = 1'b0, rst = 1'b1;
  logic [CW-1:0] line_len = 12'd40, high_len = 12'd12;
  logic          hdrv_off = 1'b0, pwr_down = 1'b0;
  logic          hout, src_sby;

  int checks = 0, errors = 0;
  realtime last_t = 0.0, last_len = 0.0;
  logic    last_lvl = 1'b0;
  realtime min_phase = 240.0;
  bit      done = 1'b0;

  always #(TPLL/2) clk_pll = ~clk_pll;
  always #(TSBY/2) clk_sby = ~clk_sby;

  hdrive_src_switch #(.CW(CW), .SBY_HALF(HALF)) u0 (
    .clk_pll, .clk_sby, .rst, .line_len, .high_len,
    .hdrv_off, .pwr_down, .hout, .src_sby
  );

  task automatic check(input bit ok, input string req, input string what,
                       input realtime act, input realtime exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  // R9: every phase length observed at the pin
  always @(hout) begin
    if (!rst) begin
      last_len = $realtime - last_t;
      last_lvl = ~hout;
      last_t   = $realtime;
      if (last_len < min_phase - EPS)
        check(1'b0, "R9", "runt phase", last_len, min_phase);
    end
  end

  task automatic measure(output realtime h, output realtime l);
    realtime a, b, c;
    @(posedge hout); a = $realtime;
    @(negedge hout); b = $realtime;
    @(posedge hout); c = $realtime;
    h = b - a;
    l = c - b;
  endtask

  task automatic t_reset;
    #(TSBY*10);
    check(hout == 1'b0, "R1", "hout in reset", real'(hout), 0.0);
    check(src_sby == 1'b0, "R1", "src_sby in reset", real'(src_sby), 0.0);
    @(negedge clk_pll);
    rst = 1'b0;
    last_t = $realtime;
    #(TPLL*3);
    check(hout == 1'b0, "R1", "first phase low", real'(hout), 0.0);
  endtask

  task automatic t_pll_timing(input realtime eh, input realtime el);
    realtime h, l;
    measure(h, l);
    measure(h, l);
    check((h > eh-EPS) && (h < eh+EPS), "R2", "pll high time", h, eh);
    check((l > el-EPS) && (l < el+EPS), "R2", "pll low time", l, el);
    check(src_sby == 1'b0, "R8", "status in normal", real'(src_sby), 0.0);
  endtask

  task automatic t_enter(input bit via_off, input realtime eh, input realtime el);
    realtime nom, h, l;
    string   rq;
    rq = via_off ? "R4" : "R5";
    #(TPLL*7.3);
    if (via_off) hdrv_off = 1'b1; else pwr_down = 1'b1;
    @(posedge src_sby);
    #1;
    // R8: the status rises at the same instant as the first standby edge
    check(($realtime - last_t) < 1.5, "R8", "status with edge", $realtime - last_t, 1.0);
    nom = last_lvl ? eh : el;
    check(last_len > nom - EPS, "R6", "entry phase not shortened", last_len, nom);
    check(last_len < nom + 4*TSBY + EPS, "R6", "entry stretch bound", last_len, nom + 4*TSBY);
    measure(h, l);
    measure(h, l);
    check((h > HALF*TSBY-EPS) && (h < HALF*TSBY+EPS), "R3", "sby high time", h, HALF*TSBY);
    check((l > HALF*TSBY-EPS) && (l < HALF*TSBY+EPS), "R3", "sby low time", l, HALF*TSBY);
    check(src_sby == 1'b1, rq, "standby entered", real'(src_sby), 1.0);
  endtask

  task automatic t_leave;
    realtime nom;
    hdrv_off = 1'b0;
    pwr_down = 1'b0;
    @(negedge src_sby);
    @(hout);
    #1;
    nom = HALF*TSBY;
    check(last_len > nom - EPS, "R7", "exit phase not shortened", last_len, nom);
    check(last_len < nom + 4*TPLL + EPS, "R7", "exit stretch bound", last_len, nom + 4*TPLL);
    check(src_sby == 1'b0, "R7", "back on pll", real'(src_sby), 0.0);
  endtask

  task automatic t_either_holds;
    realtime h, l;
    pwr_down = 1'b1;
    #(TSBY*6);
    hdrv_off = 1'b0;
    #5000;
    check(src_sby == 1'b1, "R5", "held by pwr_down alone", real'(src_sby), 1.0);
    measure(h, l);
    check((h > HALF*TSBY-EPS) && (h < HALF*TSBY+EPS), "R5", "still sby timing", h, HALF*TSBY);
  endtask

  initial begin
    t_reset();
    t_pll_timing(240.0, 560.0);
    t_enter(1'b1, 240.0, 560.0);
    t_either_holds();
    line_len = 12'd30;
    high_len = 12'd15;
    t_leave();
    t_pll_timing(300.0, 300.0);
    t_enter(1'b0, 300.0, 300.0);
    t_leave();
    t_pll_timing(300.0, 300.0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      check(1'b0, "R10", "watchdog expired", $realtime, 0.0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule